// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is a master-only serial port. It takes one parallel word from the host, shifts it out most significant bit first on a serial clock that it generates itself, and shifts a word in from the far end at the same time. A single sequencing engine handles three framing styles, chosen by `cfg_fmt`. The first is a pulsed-frame style, where a one-period frame strobe comes before the data. The second is an SPI-style style with an active-low select. The third is a MICROWIRE-style command/response style, in which an 8-bit control word goes out first and then a data word is received. The word length can be set from 4 to 16 bits. The serial clock rate is an even division of the system clock.

The host sees two simple word ports. A transmit port with `tx_valid`/`tx_ready` loads a frame. A receive strobe, `rx_valid`, presents the captured word. The port starts a frame only from idle. The configuration is sampled when a frame is accepted, so any change to it takes effect from the next frame. A separate `line_oe` output drives the enable of an external line driver for as long as the port is sending bits.

Top module: `ssp_master`

## Requirements
- R1: Out of reset and whenever no frame is running, `sclk`, `sdo` and `line_oe` are low, `busy` is low and `tx_ready` is high. `sfrm` idles low when `cfg_fmt` selects the pulsed style (code 0). It idles high for the SPI style (code 1, and code 3, which behaves as code 1) and for the MICROWIRE style (code 2).
- R2: The word length is taken from `cfg_bits`. A value below 4 is treated as 4, and a value above 16 is treated as 16.
- R3: One serial half-period lasts H = `cfg_div`/2 system clocks, rounded down and never less than 1. Every data bit is one high half followed by one low half of `sclk`.
- R4: Data leaves on `sdo` most significant bit first. The line changes only when `sclk` rises, and it holds its value for the whole bit.
- R5: In the pulsed style, `sfrm` is high for exactly one serial period, from the cycle after acceptance. During that period `sclk` is high for the first half and low for the second. The first data bit follows directly.
- R6: In the SPI style, `sfrm` is low from the cycle after acceptance until the last bit ends. The frame opens with one serial period in which `sclk` stays low.
- R7: In the MICROWIRE style, `tx_data[7:0]` is sent first as an 8-bit control word, MSB first. It is followed by the programmed number of receive bits, during which `sdo` and `line_oe` are low. The lead-in is the same as in R6.
- R8: `sdi` is sampled at the system clock edge where `sclk` falls. The received word is right-justified in `rx_data`, and the unused upper bits are zero. In the MICROWIRE style, only the bits after the control word are captured.
- R9: `rx_valid` is a one-cycle pulse in the cycle after the last bit is captured, and `rx_data` holds the word in that cycle.
- R10: A word is accepted only on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` is low and `busy` is high from the cycle after acceptance until the frame ends. Between back-to-back frames, `sclk` spends at least one cycle low.
- R11: `line_oe` is high exactly during the data bits the port transmits.
- R12: The style, length and divider are fixed at acceptance. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Framing style: 0 pulsed, 1 SPI, 2 MICROWIRE, 3 as 1 |
| cfg_bits | input | 5 | Word length in bits (clamped to 4..16) |
| cfg_div | input | 8 | Serial clock divider (even, at least 2) |
| tx_valid | input | 1 | Host offers a transmit word |
| tx_data | input | 16 | Transmit word, right-justified; low byte is the control word in MICROWIRE style |
| tx_ready | output | 1 | Port idle, word can be accepted |
| busy | output | 1 | A frame is in progress |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | 16 | Received word, right-justified |
| sclk | output | 1 | Serial clock, idles low |
| sfrm | output | 1 | Frame strobe / select |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| line_oe | output | 1 | External line-driver enable |

## Verification
Take the cycle after acceptance as cycle 0. The lead-in then covers cycles 0 to 2H-1, and bit b covers 2H(b+1) to 2H(b+2)-1, high for its first H cycles. `rx_valid` is due at cycle 2HT+H, where T counts every bit in the frame, and `tx_ready` returns at cycle 2H(T+1). The bench model keeps its own cycle index from acceptance and derives each output from these formulas. It compares the outputs at the falling system clock edge of every cycle, after all registers have updated, and it drives `sdi` at that same falling edge so the bit is stable at the capturing rising edge.

// File: rtl/ssp_pkg.sv
// Shared types for the serial master.
// Assumes: the format code is 2 bits wide and the engine has three states.
package ssp_pkg;
    typedef enum logic [1:0] {
        FMT_PULSE = 2'd0,
        FMT_SPI   = 2'd1,
        FMT_MW    = 2'd2,
        FMT_ALT   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_BITS = 2'd2
    } st_e;
endpackage

// File: rtl/ssp_tick.sv
// Half-period timer: while run is high, pulses tick every `half` system clocks.
// Assumes: half >= 1, and half is stable while run is high.
module ssp_tick #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt;

    assign tick = run && (cnt == half - HALF_W'(1));

    // count system clocks within one half-period; park at zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + HALF_W'(1);
    end
endmodule

// File: rtl/ssp_ctrl.sv
// Frame sequencer: samples the configuration on acceptance, then steps through
// a one-period lead-in and the data bits, two half-periods per step.
// Assumes: tick arrives once per half-period while a frame runs.
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int WORD_MIN = 4,
    parameter int WORD_MAX = 16,
    parameter int CTRL_W   = 8,
    parameter int DIV_W    = 8,
    parameter int LEN_W    = 5,
    parameter int CNT_W    = 5,
    parameter int HALF_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_fmt,
    input  logic [LEN_W-1:0]  cfg_bits,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_valid,
    input  logic              tick,
    output st_e               st,
    output logic              phase,
    output fmt_e              fmt_q,
    output logic [LEN_W-1:0]  nbits_q,
    output logic [HALF_W-1:0] half_q,
    output logic              accept,
    output logic              capture,
    output logic              shift_en,
    output logic              last_cap,
    output logic              tx_ph,
    output logic              rx_ph
);
    logic [LEN_W-1:0]  nbits_in;
    logic [HALF_W-1:0] half_in;
    fmt_e              fmt_in;
    logic [CNT_W-1:0]  total_in;
    logic [CNT_W-1:0]  bcnt;

    // clamp the requested word length into the supported range
    always_comb begin
        if (cfg_bits < LEN_W'(WORD_MIN))      nbits_in = LEN_W'(WORD_MIN);
        else if (cfg_bits > LEN_W'(WORD_MAX)) nbits_in = LEN_W'(WORD_MAX);
        else                                  nbits_in = cfg_bits;
    end

    // derive half-period, effective style and total bit count from the inputs
    always_comb begin
        half_in  = (cfg_div[DIV_W-1:1] == '0) ? HALF_W'(1) : cfg_div[DIV_W-1:1];
        fmt_in   = (cfg_fmt == 2'd3) ? FMT_SPI : fmt_e'(cfg_fmt);
        total_in = (fmt_in == FMT_MW) ? CNT_W'(nbits_in) + CNT_W'(CTRL_W)
                                      : CNT_W'(nbits_in);
    end

    assign accept   = tx_valid && (st == ST_IDLE);
    assign rx_ph    = (bcnt <= CNT_W'(nbits_q));
    assign tx_ph    = (fmt_q != FMT_MW) || !rx_ph;
    assign capture  = tick && (st == ST_BITS) && !phase;
    assign shift_en = tick && (st == ST_BITS) && phase && (bcnt != CNT_W'(1));
    assign last_cap = capture && (bcnt == CNT_W'(1));

    // frame state machine: idle -> lead-in period -> data bits -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            phase   <= 1'b0;
            bcnt    <= '0;
            fmt_q   <= FMT_PULSE;
            nbits_q <= LEN_W'(WORD_MIN);
            half_q  <= HALF_W'(1);
        end else begin
            case (st)
                ST_IDLE: begin
                    fmt_q <= fmt_in;
                    if (tx_valid) begin
                        st      <= ST_LEAD;
                        phase   <= 1'b0;
                        bcnt    <= total_in;
                        nbits_q <= nbits_in;
                        half_q  <= half_in;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (phase) st <= ST_BITS;
                        phase <= !phase;
                    end
                end
                ST_BITS: begin
                    if (tick) begin
                        if (phase && bcnt == CNT_W'(1)) st <= ST_IDLE;
                        else if (phase)                 bcnt <= bcnt - CNT_W'(1);
                        phase <= !phase;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ssp_dpath.sv
// Shift datapath: a transmit register with its MSB on the line, and a receive
// register that fills from the right.
// Assumes: load, shift and capture strobes come from the sequencer and never coincide.
module ssp_dpath #(
    parameter int WORD_MAX = 16,
    parameter int CTRL_W   = 8,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                fmt_mw,
    input  logic [LEN_W-1:0]    nbits,
    input  logic [WORD_MAX-1:0] tx_data,
    input  logic                shift_en,
    input  logic                capture,
    input  logic                rx_en,
    input  logic                last_cap,
    input  logic                sdi,
    output logic                sdo_bit,
    output logic                rx_valid,
    output logic [WORD_MAX-1:0] rx_data
);
    localparam int SR_W = WORD_MAX + CTRL_W;

    logic [SR_W-1:0]     sreg;
    logic [WORD_MAX-1:0] rxs;

    assign sdo_bit = sreg[SR_W-1];

    // transmit shifter: left-align the outgoing bits, then move one bit per period
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg <= '0;
        else if (load && fmt_mw)
            sreg <= {tx_data[CTRL_W-1:0], {WORD_MAX{1'b0}}};
        else if (load)
            sreg <= {tx_data << (WORD_MAX - int'(nbits)), {CTRL_W{1'b0}}};
        else if (shift_en) sreg <= {sreg[SR_W-2:0], 1'b0};
    end

    // receive shifter and output word with its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxs      <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last_cap;
            if (load)                  rxs <= '0;
            else if (capture && rx_en) rxs <= {rxs[WORD_MAX-2:0], sdi};
            if (last_cap)              rx_data <= {rxs[WORD_MAX-2:0], sdi};
        end
    end
endmodule

// File: rtl/ssp_master.sv
// Multi-format serial master: one engine runs the pulsed-frame, SPI-style
// and MICROWIRE-style framings over a programmable 4..16 bit word.
// Assumes: cfg_div is even and at least 2 (odd values round down, 0/1 act as 2).
module ssp_master
    import ssp_pkg::*;
#(
    parameter int WORD_MIN = 4,
    parameter int WORD_MAX = 16,
    parameter int CTRL_W   = 8,
    parameter int DIV_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     cfg_fmt,
    input  logic [$clog2(WORD_MAX+1)-1:0]  cfg_bits,
    input  logic [DIV_W-1:0]               cfg_div,
    input  logic                           tx_valid,
    input  logic [WORD_MAX-1:0]            tx_data,
    output logic                           tx_ready,
    output logic                           busy,
    output logic                           rx_valid,
    output logic [WORD_MAX-1:0]            rx_data,
    output logic                           sclk,
    output logic                           sfrm,
    output logic                           sdo,
    input  logic                           sdi,
    output logic                           line_oe
);
    localparam int LEN_W  = $clog2(WORD_MAX + 1);
    localparam int CNT_W  = $clog2(WORD_MAX + CTRL_W + 1);
    localparam int HALF_W = DIV_W - 1;

    st_e               st;
    fmt_e              fmt_q;
    logic              phase, tick, accept, capture, shift_en, last_cap;
    logic              tx_ph, rx_ph, sdo_bit;
    logic [LEN_W-1:0]  nbits_q;
    logic [HALF_W-1:0] half_q;

    ssp_tick #(.HALF_W(HALF_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(st != ST_IDLE), .half(half_q), .tick(tick)
    );

    ssp_ctrl #(
        .WORD_MIN(WORD_MIN), .WORD_MAX(WORD_MAX), .CTRL_W(CTRL_W), .DIV_W(DIV_W),
        .LEN_W(LEN_W), .CNT_W(CNT_W), .HALF_W(HALF_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_bits(cfg_bits),
        .cfg_div(cfg_div), .tx_valid(tx_valid), .tick(tick), .st(st),
        .phase(phase), .fmt_q(fmt_q), .nbits_q(nbits_q), .half_q(half_q),
        .accept(accept), .capture(capture), .shift_en(shift_en),
        .last_cap(last_cap), .tx_ph(tx_ph), .rx_ph(rx_ph)
    );

    ssp_dpath #(.WORD_MAX(WORD_MAX), .CTRL_W(CTRL_W), .LEN_W(LEN_W)) u_dpath (
        .clk(clk), .rst_n(rst_n), .load(accept), .fmt_mw(cfg_fmt == 2'd2),
        .nbits(cfg_bits < LEN_W'(WORD_MIN) ? LEN_W'(WORD_MIN) :
               cfg_bits > LEN_W'(WORD_MAX) ? LEN_W'(WORD_MAX) : cfg_bits),
        .tx_data(tx_data), .shift_en(shift_en), .capture(capture),
        .rx_en(rx_ph), .last_cap(last_cap), .sdi(sdi), .sdo_bit(sdo_bit),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // pin decode from the sequencer state
    always_comb begin
        tx_ready = (st == ST_IDLE);
        busy     = (st != ST_IDLE);
        line_oe  = (st == ST_BITS) && tx_ph;
        sdo      = line_oe && sdo_bit;
        case (st)
            ST_LEAD: sclk = (fmt_q == FMT_PULSE) && !phase;
            ST_BITS: sclk = !phase;
            default: sclk = 1'b0;
        endcase
        if (fmt_q == FMT_PULSE) sfrm = (st == ST_LEAD);
        else                    sfrm = (st == ST_IDLE);
    end
endmodule

// File: rtl/ssp_master_chk.sv
// Port-level protocol checker for ssp_master, attached with bind below.
// Assumes: synchronous active-low reset on rst_n.
module ssp_master_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic busy,
    input logic rx_valid,
    input logic sclk,
    input logic sdo,
    input logic line_oe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdo && !line_oe));
    // R4
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk && $past(sclk)) |-> $stable(sdo));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R9
    done_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);
    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> busy);
    // R11
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> busy);
endmodule

bind ssp_master ssp_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .busy(busy), .rx_valid(rx_valid), .sclk(sclk), .sdo(sdo), .line_oe(line_oe)
);

// File: tb/ssp_master_tb.sv
// Bench: a behavioural per-cycle model indexed by cycles since acceptance,
// compared with every output at each falling system clock edge.
module ssp_master_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, tx_valid, tx_ready, busy, rx_valid;
    logic        sclk, sfrm, sdo, sdi, line_oe;
    logic [1:0]  cfg_fmt;
    logic [4:0]  cfg_bits;
    logic [7:0]  cfg_div;
    logic [15:0] tx_data, rx_data, rx_pat;
    string       cur_tag;
    int          n_chk = 0, n_fail = 0;

    ssp_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_bits(cfg_bits),
        .cfg_div(cfg_div), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data),
        .sclk(sclk), .sfrm(sfrm), .sdo(sdo), .sdi(sdi), .line_oe(line_oe)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int map_fmt(input int f);
        return (f == 3) ? 1 : f;
    endfunction

    // model state
    bit          act = 0, start_nx = 0;
    int          k, H, N, T, mf, q_fmt;
    logic [15:0] txw, rxw;
    string       ftag;

    always @(negedge clk) begin : model
        int b, r, rb, e_sclk, e_sfrm, e_sdo, e_oe, e_rv;
        if (!rst_n) begin
            act = 0; start_nx = 0; q_fmt = 0; sdi = 1'b1;
        end else begin
            if (start_nx) begin
                act = 1; k = 0; start_nx = 0;
            end else if (act) begin
                k++;
                if (k == 2*H*(T+1)) act = 0;
            end
            e_sclk = 0; e_sdo = 0; e_oe = 0; e_rv = 0;
            e_sfrm = (q_fmt == 0) ? 0 : 1;
            sdi = 1'b1;
            if (act) begin
                if (k < 2*H) begin
                    e_sclk = (mf == 0 && k < H) ? 1 : 0;
                    e_sfrm = (mf == 0) ? 1 : 0;
                end else begin
                    b = (k - 2*H) / (2*H);
                    r = (k - 2*H) % (2*H);
                    e_sclk = (r < H) ? 1 : 0;
                    e_sfrm = 0;
                    rb = (mf == 2) ? b - 8 : b;
                    if (mf != 2 || b < 8) begin
                        e_oe  = 1;
                        e_sdo = (mf == 2) ? int'(txw[7-b]) : int'(txw[N-1-b]);
                    end
                    if (rb >= 0) sdi = rxw[N-1-rb];
                    e_rv = (k == 2*H*T + H) ? 1 : 0;
                end
            end
            chk(act ? "R3" : "R1", sclk, e_sclk);
            chk(act ? ((mf == 0) ? "R5" : "R6") : "R1", sfrm, e_sfrm);
            chk(act ? ((mf == 2) ? "R7" : "R4") : "R1", sdo, e_sdo);
            chk("R11", line_oe, e_oe);
            chk("R10", busy, act ? 1 : 0);
            chk("R10", tx_ready, act ? 0 : 1);
            chk("R9", rx_valid, e_rv);
            if (e_rv) chk(ftag, rx_data, rxw);
            q_fmt = act ? mf : map_fmt(cfg_fmt);
            if (!act && tx_valid) begin
                start_nx = 1;
                mf  = map_fmt(cfg_fmt);
                N   = (cfg_bits < 4) ? 4 : (cfg_bits > 16) ? 16 : int'(cfg_bits);
                H   = (cfg_div / 2 < 1) ? 1 : int'(cfg_div) / 2;
                T   = (mf == 2) ? N + 8 : N;
                txw = tx_data;
                rxw = rx_pat & 16'((1 << N) - 1);
                ftag = cur_tag;
            end
        end
    end

    task automatic wait_accept();
        forever begin
            @(negedge clk);
            if (tx_ready) break;
        end
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic frame(input int fmt, input int bits, input int div,
                         input logic [15:0] data, input logic [15:0] rxp,
                         input string tag, input bit midchg);
        @(posedge clk); #1;
        cfg_fmt = 2'(fmt); cfg_bits = 5'(bits); cfg_div = 8'(div);
        tx_data = data; rx_pat = rxp; cur_tag = tag; tx_valid = 1'b1;
        wait_accept();
        if (midchg) begin   // R12: settings moved mid-frame must not matter
            repeat (10) @(posedge clk); #1;
            cfg_fmt = 2'd2; cfg_bits = 5'd16; cfg_div = 8'd2;
        end
        do @(negedge clk); while (busy);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin : stim
        rst_n = 1'b0; cfg_fmt = 2'd0; cfg_bits = 5'd8; cfg_div = 8'd4;
        tx_valid = 1'b0; tx_data = '0; rx_pat = '0; cur_tag = "R8";
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", sclk, 0); chk("R1", sfrm, 0); chk("R1", busy, 0);
        chk("R1", tx_ready, 1); chk("R1", line_oe, 0); chk("R1", rx_data, 0);
        // R1 idle select level for SPI style
        @(posedge clk); #1; cfg_fmt = 2'd1;
        repeat (3) @(posedge clk);
        frame(0, 8, 4, 16'h00A5, 16'h003C, "R8", 0);   // pulsed
        frame(1, 16, 2, 16'hBEEF, 16'h1234, "R8", 0);  // SPI, full width
        frame(2, 12, 6, 16'h009B, 16'h0ABC, "R7", 0);  // MICROWIRE
        frame(0, 2, 1, 16'h000D, 16'h0006, "R2", 0);   // R2 low clamp, smallest divider
        frame(1, 20, 5, 16'hC3A5, 16'h5A5A, "R2", 0);  // R2 high clamp, odd divider
        frame(3, 7, 2, 16'h0055, 16'h002A, "R6", 0);   // code 3 as SPI
        frame(0, 6, 4, 16'h002D, 16'h0013, "R12", 1);  // R12
        // R10 back-to-back: tx_valid held high across a running frame
        @(posedge clk); #1;
        cfg_fmt = 2'd1; cfg_bits = 5'd4; cfg_div = 8'd2;
        tx_data = 16'h0009; rx_pat = 16'h0005; cur_tag = "R10"; tx_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (tx_ready) break;
        end
        @(posedge clk); #1;
        tx_data = 16'h0006; rx_pat = 16'h000A;
        wait_accept();
        do @(negedge clk); while (busy);
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule